// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Read-During-Write Modes

This block is a two-port storage array. Each of its two ports, A and B, has its own enable, write enable, address, write data and read data. The ports work independently. The only thing they share is the array contents and a common clock. Every input is sampled on the rising clock edge, and nothing in the block changes between edges. The read output of a port holds its value until that port performs its next enabled access.

Each port has a parameter that sets what its read output shows in a cycle where that same port writes. The choices are the contents that stood at the address before the write, the word being written, or the port's previous output left unchanged. A second per-port parameter inserts a pipeline register after the read stage, which trades one extra cycle of read latency for a shorter output path. Each port also has a synchronous reset that clears its output registers and leaves the stored words untouched. The default size is 1024 words of 36 bits.

Top module: `dualPortRam`

## Requirements
- R1: With the output register off, an enabled read (enable 1, write enable 0) presents the stored word at the sampled address on the port's read data right after the edge that sampled it.
- R2: With the output register on, the same read result appears one edge later, which is two edges after the address was sampled.
- R3: In old-data mode (mode code 0), an enabled write shows the word that was stored at that address before the write.
- R4: In new-data mode (mode code 1), an enabled write shows the word being written.
- R5: In hold mode (mode code 2), an enabled write leaves the port's read data unchanged.
- R6: While a port's enable is low, that port ignores its write enable and its read data does not change. A later read of the address it was given returns the earlier contents.
- R7: A port's synchronous reset drives its read data to zero on the next edge, including the pipeline stage. The stored words are not changed.
- R8: When one port reads an address that the other port writes in the same cycle, the read returns the old word. Both ports see the new word from the next access on.
- R9: Simultaneous accesses by the two ports to different addresses each complete as if the other port were idle.
- R10: If both ports write the same address in the same cycle, the stored word is undefined. The bench reports this as a collision and does not check that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rstA | input | 1 | Port A synchronous reset of its output registers |
| enA | input | 1 | Port A access enable |
| weA | input | 1 | Port A write enable, used only when enA is 1 |
| addrA | input | $clog2(DEPTH) | Port A word address |
| wdataA | input | WIDTH | Port A write data |
| rdataA | output | WIDTH | Port A read data |
| rstB | input | 1 | Port B synchronous reset of its output registers |
| enB | input | 1 | Port B access enable |
| weB | input | 1 | Port B write enable, used only when enB is 1 |
| addrB | input | $clog2(DEPTH) | Port B word address |
| wdataB | input | WIDTH | Port B write data |
| rdataB | output | WIDTH | Port B read data |

## Verification
Two instances run with different configurations, so that every write mode and both latency settings are covered. The bench first overwrites a location through a port in old-data mode. A design that forwarded the incoming word there would show the new word instead of the previous contents. A cross-port case has one port read an address in the same cycle as the other port writes it: a design whose write landed before the read would leak the new word early. Writes with the enable low, followed by a read-back, expose a write enable that slips past the enable. A reset in the middle of the run, followed by a read, catches a reset that clears the array or misses the pipeline stage.

// File: rtl/dprPkg.sv
package dprPkg;

  // Read-during-write behaviour of one port
  typedef enum logic [1:0] {
    RDW_OLD  = 2'd0,
    RDW_NEW  = 2'd1,
    RDW_HOLD = 2'd2
  } rdwMode_e;

  // Strobes from a port controller to the datapath
  typedef struct packed {
    logic wr;      // commit write data into the array
    logic load;    // update the read stage
    logic selNew;  // read stage takes write data instead of array word
    logic shift;   // advance the optional output stage
    logic clr;     // synchronous clear of the output registers
  } portStb_t;

endpackage

// File: rtl/dprPortCtrl.sv
module dprPortCtrl
  import dprPkg::*;
#(
  parameter rdwMode_e MODE = RDW_OLD
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     we,
  output portStb_t stb
);

  localparam bit IS_HOLD = (MODE == RDW_HOLD);
  localparam bit IS_NEW  = (MODE == RDW_NEW);

  // remembers that the read stage was updated last cycle
  logic enQ;

  always_ff @(posedge clk) begin
    if (rst) enQ <= 1'b0;
    else     enQ <= en;
  end

  always_comb begin
    stb.wr     = en & we;
    stb.load   = en & ~(we & IS_HOLD);
    stb.selNew = we & IS_NEW;
    stb.shift  = enQ;
    stb.clr    = rst;
  end

endmodule

// File: rtl/dprDatapath.sv
module dprDatapath
  import dprPkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int WIDTH    = 36,
  parameter int AW       = $clog2(DEPTH),
  parameter bit OUTREG_A = 1'b0,
  parameter bit OUTREG_B = 1'b0
) (
  input  logic             clk,
  input  portStb_t         stb   [2],
  input  logic [AW-1:0]    addr  [2],
  input  logic [WIDTH-1:0] wdata [2],
  output logic [WIDTH-1:0] rdata [2]
);

  logic [WIDTH-1:0] mem [DEPTH];

  // array update: both ports in one process, port order fixed
  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (stb[p].wr) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam bit OREG = (p == 0) ? OUTREG_A : OUTREG_B;

    logic [WIDTH-1:0] latQ;

    // read stage samples the array before this edge's write lands
    always_ff @(posedge clk) begin
      if (stb[p].clr)       latQ <= '0;
      else if (stb[p].load) latQ <= stb[p].selNew ? wdata[p] : mem[addr[p]];
    end

    if (OREG) begin : g_pipe
      logic [WIDTH-1:0] pipeQ;
      always_ff @(posedge clk) begin
        if (stb[p].clr)        pipeQ <= '0;
        else if (stb[p].shift) pipeQ <= latQ;
      end
      assign rdata[p] = pipeQ;
    end else begin : g_direct
      logic unusedShift;
      assign unusedShift = stb[p].shift;
      assign rdata[p]    = latQ;
    end
  end

endmodule

// File: rtl/dualPortRam.sv
module dualPortRam
  import dprPkg::*;
#(
  parameter int       DEPTH    = 1024,
  parameter int       WIDTH    = 36,
  parameter rdwMode_e MODE_A   = RDW_NEW,
  parameter rdwMode_e MODE_B   = RDW_NEW,
  parameter bit       OUTREG_A = 1'b0,
  parameter bit       OUTREG_B = 1'b0,
  localparam int      AW       = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstA,
  input  logic             enA,
  input  logic             weA,
  input  logic [AW-1:0]    addrA,
  input  logic [WIDTH-1:0] wdataA,
  output logic [WIDTH-1:0] rdataA,
  input  logic             rstB,
  input  logic             enB,
  input  logic             weB,
  input  logic [AW-1:0]    addrB,
  input  logic [WIDTH-1:0] wdataB,
  output logic [WIDTH-1:0] rdataB
);

  portStb_t         stbArr  [2];
  logic [AW-1:0]    addrArr [2];
  logic [WIDTH-1:0] wdArr   [2];
  logic [WIDTH-1:0] rdArr   [2];

  assign addrArr[0] = addrA;
  assign addrArr[1] = addrB;
  assign wdArr[0]   = wdataA;
  assign wdArr[1]   = wdataB;
  assign rdataA     = rdArr[0];
  assign rdataB     = rdArr[1];

  dprPortCtrl #(.MODE(MODE_A)) u_ctrlA (
    .clk (clk),
    .rst (rstA),
    .en  (enA),
    .we  (weA),
    .stb (stbArr[0])
  );

  dprPortCtrl #(.MODE(MODE_B)) u_ctrlB (
    .clk (clk),
    .rst (rstB),
    .en  (enB),
    .we  (weB),
    .stb (stbArr[1])
  );

  dprDatapath #(
    .DEPTH    (DEPTH),
    .WIDTH    (WIDTH),
    .AW       (AW),
    .OUTREG_A (OUTREG_A),
    .OUTREG_B (OUTREG_B)
  ) u_datapath (
    .clk   (clk),
    .stb   (stbArr),
    .addr  (addrArr),
    .wdata (wdArr),
    .rdata (rdArr)
  );

endmodule

// File: rtl/dprChecker.sv
module dprChecker
  import dprPkg::*;
#(
  parameter int       WIDTH    = 36,
  parameter rdwMode_e MODE_A   = RDW_NEW,
  parameter rdwMode_e MODE_B   = RDW_NEW,
  parameter bit       OUTREG_A = 1'b0,
  parameter bit       OUTREG_B = 1'b0
) (
  input logic             clk,
  input logic             rstA,
  input logic             enA,
  input logic             weA,
  input logic [WIDTH-1:0] wdataA,
  input logic [WIDTH-1:0] rdataA,
  input logic             rstB,
  input logic             enB,
  input logic             weB,
  input logic [WIDTH-1:0] wdataB,
  input logic [WIDTH-1:0] rdataB
);

  // R7
  rst_a_clears_chk: assert property (@(posedge clk) rstA |=> rdataA == '0);
  // R7
  rst_b_clears_chk: assert property (@(posedge clk) rstB |=> rdataB == '0);

  // R6
  idle_a_steady_chk: assert property (@(posedge clk) disable iff (rstA)
    (!enA && !$past(enA)) |=> $stable(rdataA));
  // R6
  idle_b_steady_chk: assert property (@(posedge clk) disable iff (rstB)
    (!enB && !$past(enB)) |=> $stable(rdataB));

  if (MODE_A == RDW_NEW && !OUTREG_A) begin : g_newA
    // R4
    new_a_direct_chk: assert property (@(posedge clk) disable iff (rstA)
      (enA && weA) |=> rdataA == $past(wdataA));
  end
  if (MODE_A == RDW_NEW && OUTREG_A) begin : g_newApipe
    // R4
    new_a_piped_chk: assert property (@(posedge clk) disable iff (rstA)
      ($past(enA && weA) && !$past(rstA)) |=> rdataA == $past(wdataA, 2));
  end
  if (MODE_B == RDW_NEW && !OUTREG_B) begin : g_newB
    // R4
    new_b_direct_chk: assert property (@(posedge clk) disable iff (rstB)
      (enB && weB) |=> rdataB == $past(wdataB));
  end
  if (MODE_B == RDW_NEW && OUTREG_B) begin : g_newBpipe
    // R4
    new_b_piped_chk: assert property (@(posedge clk) disable iff (rstB)
      ($past(enB && weB) && !$past(rstB)) |=> rdataB == $past(wdataB, 2));
  end
  if (MODE_A == RDW_HOLD && !OUTREG_A) begin : g_holdA
    // R5
    hold_a_chk: assert property (@(posedge clk) disable iff (rstA)
      (enA && weA) |=> $stable(rdataA));
  end
  if (MODE_B == RDW_HOLD && !OUTREG_B) begin : g_holdB
    // R5
    hold_b_chk: assert property (@(posedge clk) disable iff (rstB)
      (enB && weB) |=> $stable(rdataB));
  end

endmodule

bind dualPortRam dprChecker #(
  .WIDTH    (WIDTH),
  .MODE_A   (MODE_A),
  .MODE_B   (MODE_B),
  .OUTREG_A (OUTREG_A),
  .OUTREG_B (OUTREG_B)
) u_dprChecker (
  .clk    (clk),
  .rstA   (rstA),
  .enA    (enA),
  .weA    (weA),
  .wdataA (wdataA),
  .rdataA (rdataA),
  .rstB   (rstB),
  .enB    (enB),
  .weB    (weB),
  .wdataB (wdataB),
  .rdataB (rdataB)
);

// File: tb/test_dualPortRam.sv
`timescale 1ns/1ps
module test_dualPortRam;
  import dprPkg::*;

  localparam int W = 36;
  localparam int D = 1024;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic         rstA = 1'b1, enA = 1'b0, weA = 1'b0;
  logic         rstB = 1'b1, enB = 1'b0, weB = 1'b0;
  logic [9:0]   addrA = '0, addrB = '0;
  logic [W-1:0] wdataA = '0, wdataB = '0;
  logic [W-1:0] rdA, rdB, rdA2, rdB2;

  // main: A old-data direct, B new-data piped
  dualPortRam #(.DEPTH(D), .WIDTH(W), .MODE_A(RDW_OLD), .MODE_B(RDW_NEW),
                .OUTREG_A(1'b0), .OUTREG_B(1'b1)) i_dualPortRam (
    .clk(clk), .rstA(rstA), .enA(enA), .weA(weA), .addrA(addrA), .wdataA(wdataA),
    .rdataA(rdA), .rstB(rstB), .enB(enB), .weB(weB), .addrB(addrB),
    .wdataB(wdataB), .rdataB(rdB));

  // alternate: A hold direct, B old-data piped
  dualPortRam #(.DEPTH(D), .WIDTH(W), .MODE_A(RDW_HOLD), .MODE_B(RDW_OLD),
                .OUTREG_A(1'b0), .OUTREG_B(1'b1)) i_dualPortRamAlt (
    .clk(clk), .rstA(rstA), .enA(enA), .weA(weA), .addrA(addrA), .wdataA(wdataA),
    .rdataA(rdA2), .rstB(rstB), .enB(enB), .weB(weB), .addrB(addrB),
    .wdataB(wdataB), .rdataB(rdB2));

  // reference model, indexed q: 0 mainA, 1 mainB, 2 altA, 3 altB
  logic [W-1:0] refMem [D];
  bit           refKnown [D];
  logic [W-1:0] mLat [4], mPipe [4];
  bit           mLatK [4], mPipeK [4], mEnQ [4];
  int           mMode [4] = '{0, 1, 2, 0};
  bit           mOreg [4] = '{1'b0, 1'b1, 1'b0, 1'b1};

  typedef struct {
    int           due;
    int           q;
    logic [W-1:0] val;
    string        tag;
  } item_t;
  item_t sbq[$];
  item_t it;

  int edgeCnt = 0;
  int total = 0;
  int bad = 0;
  int collisions = 0;
  bit done = 1'b0;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  function automatic logic [W-1:0] pat(input int i);
    return {4'hA, 32'(i) * 32'h0103_0507 + 32'h11};
  endfunction

  function automatic logic [W-1:0] outOf(input int q);
    case (q)
      0:       return rdA;
      1:       return rdB;
      2:       return rdA2;
      default: return rdB2;
    endcase
  endfunction

  // driver: one call per clock, pushes what each output must show
  task automatic step(input bit rA, input bit eA, input bit wA, input int aA,
                      input logic [W-1:0] dA, input bit rB, input bit eB,
                      input bit wB, input int aB, input logic [W-1:0] dB,
                      input string tag);
    @(posedge clk);
    #2;
    rstA = rA; enA = eA; weA = wA; addrA = aA[9:0]; wdataA = dA;
    rstB = rB; enB = eB; weB = wB; addrB = aB[9:0]; wdataB = dB;
    for (int q = 0; q < 4; q++) begin
      bit r, e, w;
      int a;
      logic [W-1:0] d;
      if (q % 2 == 0) begin r = rA; e = eA; w = wA; a = aA; d = dA; end
      else            begin r = rB; e = eB; w = wB; a = aB; d = dB; end
      if (r) begin
        mLat[q] = '0; mLatK[q] = 1'b1; mPipe[q] = '0; mPipeK[q] = 1'b1; mEnQ[q] = 1'b0;
      end else begin
        if (mEnQ[q]) begin mPipe[q] = mLat[q]; mPipeK[q] = mLatK[q]; end
        if (e) begin
          if (!w || mMode[q] == 0) begin mLat[q] = refMem[a]; mLatK[q] = refKnown[a]; end
          else if (mMode[q] == 1)  begin mLat[q] = d; mLatK[q] = 1'b1; end
        end
        mEnQ[q] = e;
      end
      if (mOreg[q] ? mPipeK[q] : mLatK[q])
        sbq.push_back('{edgeCnt + 1, q, mOreg[q] ? mPipe[q] : mLat[q], tag});
    end
    if (eA && wA && eB && wB && aA == aB) begin
      // R10: undefined result, reported and excluded from checking
      collisions++;
      refKnown[aA] = 1'b0;
      $display("note: R10 write collision at address %0d, stored word not checked", aA);
    end else begin
      if (eA && wA) begin refMem[aA] = dA; refKnown[aA] = 1'b1; end
      if (eB && wB) begin refMem[aB] = dB; refKnown[aB] = 1'b1; end
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, '0, 0, 0, 0, 0, '0, tag);
  endtask

  // monitor: compares at the falling edge after each rising edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == edgeCnt) begin
      it = sbq.pop_front();
      total++;
      if (outOf(it.q) !== it.val) begin
        bad++;
        $display("FAIL %s output%0d edge %0d: actual=%h expected=%h",
                 it.tag, it.q, edgeCnt, outOf(it.q), it.val);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    step(1, 0, 0, 0, '0, 1, 0, 0, 0, '0, "R7");
    step(1, 0, 0, 0, '0, 1, 0, 0, 0, '0, "R7");
    // R5: alternate port A holds its output through writes
    for (int i = 0; i < 8; i++) step(0, 1, 1, i, pat(i), 0, 0, 0, 0, '0, "R5");
    // R4: new-data port shows written word (piped)
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, '0, 0, 1, 1, 100 + i, pat(100 + i), "R4");
    idle("R2");
    // R9 with R1/R2: both ports read different addresses together
    for (int i = 0; i < 4; i++) step(0, 1, 0, i, '0, 0, 1, 0, 100 + i, '0, "R9");
    for (int i = 4; i < 8; i++) step(0, 1, 0, i, '0, 0, 0, 0, 0, '0, "R1");
    idle("R2");
    // R3: overwrite shows previous contents
    step(0, 1, 1, 3, pat(33), 0, 0, 0, 0, '0, "R3");
    step(0, 0, 0, 0, '0, 0, 1, 1, 101, pat(201), "R3");
    idle("R3");
    // R6: write enable ignored while enable low
    step(0, 0, 1, 3, 36'h0_BAD0_BAD0, 0, 0, 1, 101, 36'h0_DEAD_0000, "R6");
    idle("R6");
    step(0, 1, 0, 3, '0, 0, 1, 0, 101, '0, "R6");
    idle("R6");
    // R8: cross-port read of an address being written
    step(0, 1, 1, 50, pat(50), 0, 0, 0, 0, '0, "R8");
    step(0, 1, 0, 50, '0, 0, 1, 1, 50, pat(150), "R8");
    step(0, 1, 0, 50, '0, 0, 1, 0, 50, '0, "R8");
    idle("R8");
    // R7: reset mid-run, contents survive
    step(1, 1, 0, 0, '0, 1, 1, 0, 100, '0, "R7");
    step(0, 1, 0, 0, '0, 0, 1, 0, 100, '0, "R7");
    idle("R7");
    // R10: same-address write from both ports
    step(0, 1, 1, 200, pat(1), 0, 1, 1, 200, pat(2), "R10");
    step(0, 1, 0, 200, '0, 0, 1, 0, 200, '0, "R10");
    for (int i = 0; i < 4; i++) idle("R6");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("collisions reported: %0d", collisions);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule